// File: doc/BRIEF.md
# Privileged Control and Status Register Unit

This block is the machine-, supervisor- and user-mode control and status register file of a small 32-bit hart. The hart issues one request per cycle. A request carries a 12-bit register address, an operation (read, write, bit-set or bit-clear), an operand and the privilege level it runs at. In the same cycle the unit returns the register's prior value and an illegal-instruction flag. On the next clock edge it commits the modified value. There is no separate read phase, so every read-modify-write is atomic.

Illegal writes to fields with write-any/read-legal semantics are dropped in silence, without a trap. The unit also holds the 64-bit cycle and retired-instruction counters, and per-mode enable masks decide whether lower privilege levels may read them. A second, debugger-facing port reads and writes registers without privilege checks and without ever trapping. Instead of raising an exception, it reports whether the addressed register exists.

Top module: `csr_unit`

## Requirements
- R1: The operation codes are 0 read, 1 write, 2 set (old | operand) and 3 clear (old & ~operand). While the request is valid, `req_rdata_o` shows the prior value in that same cycle. The legalised new value is visible on the next cycle.
- R2: Address bits [9:8] give the lowest privilege that may access a register (0 user, 1 supervisor, 3 machine). An access from a lower level, or to an address that does not exist, raises `req_illegal_o`, returns 0 and changes no state.
- R3: Addresses with bits [11:10] = 2'b11 are read-only, and any write to them is illegal. A set or clear with `req_src_x0_i` high, and a read, performs no write. Such a request is legal on read-only registers and changes nothing.
- R4: The debug port never checks privilege and never traps. `dbg_exists_o` reports whether `dbg_addr_i` exists. A debug write applies only while `req_valid_i` is low, and only to an existing register that is not read-only.
- R5: The ISA register (0x301) always reads 0x40141100. Writes to it are legal and ignored.
- R6: The trap-vector registers (0x305 machine, 0x105 supervisor) always read mode bits [1:0] as 0. A write updates base bits [31:2] whatever mode it requests.
- R7: The counter-enable registers (0x306 machine, 0x106 supervisor) hold bit 0 cycle, bit 1 time and bit 2 instret, and the other bits read 0. A user-range counter read (0xC00..0xC02, 0xC80..0xC82) is illegal from supervisor level unless the machine bit is set. From user level it is illegal unless both the machine and supervisor bits are set.
- R8: The supervisor status view (0x100) reads the machine status bits 1, 5, 8, 13..14, 18 (SUM), 19 (MXR) and 31. A write to the view changes only bits 1, 5, 8, 13..14, 18 and 19 of machine status.
- R9: The address-translation register (0x180) always reads 0. Writes to it are legal and ignored.
- R10: The machine status register (0x300) stores bits 1, 3, 5, 7, 8, 11..14 and 17..22, and the rest read 0. A written FS field (bits 14:13) of 0 stores 0, and any other value stores 2'b11. Bit 31 reads 1 exactly when FS is 2'b11. An MPP (bits 12:11) value of 2'b10 keeps the previous MPP.
- R11: The cycle counter (0xB00 low, 0xB80 high) counts every clock. The retired counter (0xB02, 0xB82) counts each cycle with `retire_i` high. The user addresses 0xC00/0xC80 and 0xC02/0xC82 alias them, and time (0xC01/0xC81) aliases the cycle counter.
- R12: A write to either half of a counter replaces that cycle's increment. The written half holds exactly the written value on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 12 | Register address |
| req_op_i | input | 2 | Operation: 0 read, 1 write, 2 set, 3 clear |
| req_src_x0_i | input | 1 | Operand comes from the zero register |
| req_wdata_i | input | 32 | Operand |
| req_priv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| req_rdata_o | output | 32 | Prior register value, 0 when illegal |
| req_illegal_o | output | 1 | Illegal-instruction indication |
| retire_i | input | 1 | One instruction retired this cycle |
| dbg_addr_i | input | 12 | Debug access address |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_rdata_o | output | 32 | Debug read data |
| dbg_exists_o | output | 1 | Addressed register exists |

## Verification
A table steps through all-ones writes, single-field clears and sets, and reads from each privilege level. This tells the per-register legalisation apart from a plain store, and a privilege rejection apart from an absent address. Set and clear with the zero-register flag on read-only counters separate "no write" from "write attempted". Cycle reads spaced by known distances and writes that coincide with an increment separate free counting from write priority. Debug writes issued with and without a concurrent request show whether the port arbitration holds.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int XLEN    = 32;
  localparam int CNT_W   = 2 * XLEN;
  localparam int NUM_CTR = 3;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_SET   = 2'd2;
  localparam logic [1:0] OP_CLEAR = 2'd3;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  localparam logic [11:0] A_SSTATUS    = 12'h100;
  localparam logic [11:0] A_STVEC      = 12'h105;
  localparam logic [11:0] A_SCOUNTEREN = 12'h106;
  localparam logic [11:0] A_SATP       = 12'h180;
  localparam logic [11:0] A_MSTATUS    = 12'h300;
  localparam logic [11:0] A_MISA       = 12'h301;
  localparam logic [11:0] A_MTVEC      = 12'h305;
  localparam logic [11:0] A_MCOUNTEREN = 12'h306;
  localparam logic [11:0] A_MCYCLE     = 12'hB00;
  localparam logic [11:0] A_MINSTRET   = 12'hB02;
  localparam logic [11:0] A_MCYCLEH    = 12'hB80;
  localparam logic [11:0] A_MINSTRETH  = 12'hB82;
  localparam logic [11:0] A_CYCLE      = 12'hC00;
  localparam logic [11:0] A_TIME       = 12'hC01;
  localparam logic [11:0] A_INSTRET    = 12'hC02;
  localparam logic [11:0] A_CYCLEH     = 12'hC80;
  localparam logic [11:0] A_TIMEH      = 12'hC81;
  localparam logic [11:0] A_INSTRETH   = 12'hC82;

  // stored machine status bits; supervisor view subsets
  localparam logic [XLEN-1:0] MST_WMASK  = 32'h007E_79AA;
  localparam logic [XLEN-1:0] SST_WMASK  = 32'h000C_6122;
  localparam logic [XLEN-1:0] SST_RMASK  = 32'h800C_6122;
  localparam logic [XLEN-1:0] MISA_VALUE = 32'h4014_1100;

  localparam int FS_LO  = 13;
  localparam int MPP_LO = 11;
  localparam int SD_BIT = 31;
endpackage

// File: rtl/csr_gate.sv
module csr_gate
  import csr_pkg::*;
#(
  parameter int N_CTR = NUM_CTR
) (
  input  logic [11:0]      addr_i,
  input  logic [1:0]       priv_i,
  input  logic             wr_i,
  input  logic [N_CTR-1:0] men_i,
  input  logic [N_CTR-1:0] sen_i,
  output logic             exists_o,
  output logic             illegal_o
);
  localparam logic [4:0] CTR_LIM = 5'(N_CTR);

  logic [4:0]  idx;
  logic [31:0] men_x, sen_x;
  logic        is_uctr, is_mctr, known, ro, low_priv, ctr_block;

  assign idx   = addr_i[4:0];
  assign men_x = 32'(men_i);
  assign sen_x = 32'(sen_i);

  assign is_uctr = ((addr_i[11:5] == 7'b1100_000) || (addr_i[11:5] == 7'b1100_100))
                   && (idx < CTR_LIM);
  // machine counters have no time slot
  assign is_mctr = ((addr_i[11:5] == 7'b1011_000) || (addr_i[11:5] == 7'b1011_100))
                   && (idx < CTR_LIM) && (idx != 5'd1);

  always_comb begin
    unique case (addr_i)
      A_SSTATUS, A_STVEC, A_SCOUNTEREN, A_SATP,
      A_MSTATUS, A_MISA, A_MTVEC, A_MCOUNTEREN: known = 1'b1;
      default:                                  known = 1'b0;
    endcase
  end

  assign exists_o = known | is_uctr | is_mctr;
  assign ro       = (addr_i[11:10] == 2'b11);
  assign low_priv = (priv_i < addr_i[9:8]);

  always_comb begin
    ctr_block = 1'b0;
    if (is_uctr) begin
      if (priv_i == PRV_S)      ctr_block = !men_x[idx];
      else if (priv_i == PRV_U) ctr_block = !(men_x[idx] && sen_x[idx]);
    end
  end

  assign illegal_o = !exists_o | low_priv | (wr_i & ro) | ctr_block;
endmodule

// File: rtl/csr_rdmux.sv
module csr_rdmux
  import csr_pkg::*;
#(
  parameter int N_CTR = NUM_CTR
) (
  input  logic [11:0]      addr_i,
  input  logic [XLEN-1:0]  mstatus_i,
  input  logic [XLEN-1:0]  mtvec_i,
  input  logic [XLEN-1:0]  stvec_i,
  input  logic [N_CTR-1:0] men_i,
  input  logic [N_CTR-1:0] sen_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] ins_i,
  output logic [XLEN-1:0]  rdata_o
);
  logic [XLEN-1:0] mst_view;

  assign mst_view = {mstatus_i[FS_LO+1:FS_LO] == 2'b11, mstatus_i[XLEN-2:0]};

  always_comb begin
    unique case (addr_i)
      A_MSTATUS:                   rdata_o = mst_view;
      A_SSTATUS:                   rdata_o = mst_view & SST_RMASK;
      A_MISA:                      rdata_o = MISA_VALUE;
      A_MTVEC:                     rdata_o = mtvec_i;
      A_STVEC:                     rdata_o = stvec_i;
      A_MCOUNTEREN:                rdata_o = XLEN'(men_i);
      A_SCOUNTEREN:                rdata_o = XLEN'(sen_i);
      A_MCYCLE, A_CYCLE, A_TIME:   rdata_o = cyc_i[XLEN-1:0];
      A_MCYCLEH, A_CYCLEH, A_TIMEH: rdata_o = cyc_i[CNT_W-1:XLEN];
      A_MINSTRET, A_INSTRET:       rdata_o = ins_i[XLEN-1:0];
      A_MINSTRETH, A_INSTRETH:     rdata_o = ins_i[CNT_W-1:XLEN];
      default:                     rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/csr_counters.sv
module csr_counters
  import csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic [1:0]       wr_lo_i,   // [0] cycle, [1] instret
  input  logic [1:0]       wr_hi_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [CNT_W-1:0] cyc_o,
  output logic [CNT_W-1:0] ins_o
);
  logic [CNT_W-1:0] cnt_q [2];
  logic [1:0]       inc;

  assign inc = {retire_i, 1'b1};

  for (genvar g = 0; g < 2; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cnt_q[g] <= '0;
      else if (wr_lo_i[g])  cnt_q[g] <= {cnt_q[g][CNT_W-1:XLEN], wdata_i};
      else if (wr_hi_i[g])  cnt_q[g] <= {wdata_i, cnt_q[g][XLEN-1:0]};
      else if (inc[g])      cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign cyc_o = cnt_q[0];
  assign ins_o = cnt_q[1];

  // R11
  cyc_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i == 2'b00 && wr_hi_i == 2'b00) |=> cyc_o == $past(cyc_o) + 1'b1);
  // R11
  ins_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i == 2'b00 && wr_hi_i == 2'b00 && !retire_i) |=> $stable(ins_o));
  // R12
  cyc_wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i[0] |=> cyc_o[XLEN-1:0] == $past(wdata_i));
  // R12
  ins_wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i[1] |=> ins_o[CNT_W-1:XLEN] == $past(wdata_i));
endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter logic [XLEN-1:0] MTVEC_RST = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [11:0]     req_addr_i,
  input  logic [1:0]      req_op_i,
  input  logic            req_src_x0_i,
  input  logic [XLEN-1:0] req_wdata_i,
  input  logic [1:0]      req_priv_i,
  output logic [XLEN-1:0] req_rdata_o,
  output logic            req_illegal_o,
  input  logic            retire_i,
  input  logic [11:0]     dbg_addr_i,
  input  logic            dbg_we_i,
  input  logic [XLEN-1:0] dbg_wdata_i,
  output logic [XLEN-1:0] dbg_rdata_o,
  output logic            dbg_exists_o
);
  logic [XLEN-1:0]    mstatus_q, mtvec_q, stvec_q;
  logic [NUM_CTR-1:0] men_q, sen_q;
  logic [CNT_W-1:0]   cyc, ins;

  logic            req_wr, req_bad, req_fire, dbg_fire, dbg_bad_unused;
  logic [XLEN-1:0] req_old, req_new, dbg_old;
  logic            w_en;
  logic [11:0]     w_addr;
  logic [XLEN-1:0] w_val;
  logic [1:0]      ctr_wr_lo, ctr_wr_hi;

  // a set/clear from x0 and a plain read carry no write intent
  assign req_wr = (req_op_i == OP_WRITE) ||
                  (((req_op_i == OP_SET) || (req_op_i == OP_CLEAR)) && !req_src_x0_i);

  csr_gate #(.N_CTR(NUM_CTR)) u_req_gate (
    .addr_i(req_addr_i), .priv_i(req_priv_i), .wr_i(req_wr),
    .men_i(men_q), .sen_i(sen_q), .exists_o(), .illegal_o(req_bad)
  );

  csr_gate #(.N_CTR(NUM_CTR)) u_dbg_gate (
    .addr_i(dbg_addr_i), .priv_i(PRV_M), .wr_i(1'b0),
    .men_i(men_q), .sen_i(sen_q), .exists_o(dbg_exists_o), .illegal_o(dbg_bad_unused)
  );

  csr_rdmux #(.N_CTR(NUM_CTR)) u_req_rd (
    .addr_i(req_addr_i), .mstatus_i(mstatus_q), .mtvec_i(mtvec_q), .stvec_i(stvec_q),
    .men_i(men_q), .sen_i(sen_q), .cyc_i(cyc), .ins_i(ins), .rdata_o(req_old)
  );

  csr_rdmux #(.N_CTR(NUM_CTR)) u_dbg_rd (
    .addr_i(dbg_addr_i), .mstatus_i(mstatus_q), .mtvec_i(mtvec_q), .stvec_i(stvec_q),
    .men_i(men_q), .sen_i(sen_q), .cyc_i(cyc), .ins_i(ins), .rdata_o(dbg_old)
  );

  assign req_illegal_o = req_valid_i & req_bad;
  assign req_rdata_o   = (req_valid_i && !req_bad) ? req_old : '0;
  assign dbg_rdata_o   = dbg_old;

  always_comb begin
    unique case (req_op_i)
      OP_WRITE: req_new = req_wdata_i;
      OP_SET:   req_new = req_old | req_wdata_i;
      OP_CLEAR: req_new = req_old & ~req_wdata_i;
      default:  req_new = req_old;
    endcase
  end

  assign req_fire = req_valid_i & req_wr & !req_bad;
  // debug writes yield to any hart request
  assign dbg_fire = dbg_we_i & !req_valid_i & dbg_exists_o & (dbg_addr_i[11:10] != 2'b11);

  assign w_en   = req_fire | dbg_fire;
  assign w_addr = req_fire ? req_addr_i : dbg_addr_i;
  assign w_val  = req_fire ? req_new : dbg_wdata_i;

  function automatic logic [XLEN-1:0] legal_mst(input logic [XLEN-1:0] nv,
                                                input logic [XLEN-1:0] ov);
    logic [XLEN-1:0] r;
    r = nv & MST_WMASK;
    if (r[FS_LO+1:FS_LO] != 2'b00) r[FS_LO+1:FS_LO] = 2'b11;
    if (r[MPP_LO+1:MPP_LO] == 2'b10) r[MPP_LO+1:MPP_LO] = ov[MPP_LO+1:MPP_LO];
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mstatus_q <= '0;
      mtvec_q   <= {MTVEC_RST[XLEN-1:2], 2'b00};
      stvec_q   <= '0;
      men_q     <= '0;
      sen_q     <= '0;
    end else if (w_en) begin
      unique case (w_addr)
        A_MSTATUS:    mstatus_q <= legal_mst(w_val, mstatus_q);
        A_SSTATUS:    mstatus_q <= legal_mst((mstatus_q & ~SST_WMASK) | (w_val & SST_WMASK),
                                             mstatus_q);
        A_MTVEC:      mtvec_q   <= {w_val[XLEN-1:2], 2'b00};
        A_STVEC:      stvec_q   <= {w_val[XLEN-1:2], 2'b00};
        A_MCOUNTEREN: men_q     <= w_val[NUM_CTR-1:0];
        A_SCOUNTEREN: sen_q     <= w_val[NUM_CTR-1:0];
        default: ;
      endcase
    end
  end

  assign ctr_wr_lo = {w_en && (w_addr == A_MINSTRET),  w_en && (w_addr == A_MCYCLE)};
  assign ctr_wr_hi = {w_en && (w_addr == A_MINSTRETH), w_en && (w_addr == A_MCYCLEH)};

  csr_counters u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .retire_i(retire_i),
    .wr_lo_i(ctr_wr_lo), .wr_hi_i(ctr_wr_hi), .wdata_i(w_val),
    .cyc_o(cyc), .ins_o(ins)
  );

  // R3
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i[11:10] == 2'b11 && req_op_i == OP_WRITE) |-> req_illegal_o);
  // R2
  priv_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_priv_i < req_addr_i[9:8])) |-> req_illegal_o);
  // R2
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_illegal_o |=> ($stable(mstatus_q) && $stable(mtvec_q) && $stable(stvec_q)
                       && $stable(men_q) && $stable(sen_q)));
  // R7
  ctr_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_priv_i == PRV_U && req_addr_i == A_CYCLE && !sen_q[0]) |-> req_illegal_o);
  // R10
  fs_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstatus_q[FS_LO+1:FS_LO] == 2'b00) || (mstatus_q[FS_LO+1:FS_LO] == 2'b11));
  // R6
  vec_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_illegal_o && (req_addr_i == A_MTVEC || req_addr_i == A_STVEC))
      |-> req_rdata_o[1:0] == 2'b00);
endmodule

// File: tb/csr_unit_tb.sv
module csr_unit_tb;
  import csr_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_valid_i = 1'b0;
  logic [11:0]     req_addr_i = '0;
  logic [1:0]      req_op_i = '0;
  logic            req_src_x0_i = 1'b0;
  logic [31:0]     req_wdata_i = '0;
  logic [1:0]      req_priv_i = PRV_M;
  logic [31:0]     req_rdata_o;
  logic            req_illegal_o;
  logic            retire_i = 1'b0;
  logic [11:0]     dbg_addr_i = '0;
  logic            dbg_we_i = 1'b0;
  logic [31:0]     dbg_wdata_i = '0;
  logic [31:0]     dbg_rdata_o;
  logic            dbg_exists_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  csr_unit u_dut (.*);

  typedef struct packed {
    logic [1:0]  priv;
    logic [11:0] addr;
    logic [1:0]  op;
    logic        x0;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic        exp_ill;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{PRV_M, 12'h300, OP_READ,  1'b0, 32'h0,        32'h0,        1'b0, 4'd1},  // R1 reset
    '{PRV_M, 12'h300, OP_WRITE, 1'b0, 32'hFFFF_FFFF, 32'h0,       1'b0, 4'd1},  // R1
    '{PRV_M, 12'h300, OP_READ,  1'b0, 32'h0,        32'h807E_79AA, 1'b0, 4'd10}, // R10
    '{PRV_M, 12'h300, OP_CLEAR, 1'b0, 32'h0000_6000, 32'h807E_79AA, 1'b0, 4'd1}, // R1
    '{PRV_S, 12'h100, OP_READ,  1'b0, 32'h0,        32'h000C_0122, 1'b0, 4'd8},  // R8
    '{PRV_S, 12'h100, OP_CLEAR, 1'b0, 32'h0008_0000, 32'h000C_0122, 1'b0, 4'd8}, // R8 MXR
    '{PRV_S, 12'h100, OP_SET,   1'b0, 32'h0000_2000, 32'h0004_0122, 1'b0, 4'd10}, // R10
    '{PRV_M, 12'h300, OP_READ,  1'b0, 32'h0,        32'h807679AA, 1'b0, 4'd8},  // R8
    '{PRV_S, 12'h100, OP_SET,   1'b1, 32'hFFFF_FFFF, 32'h8004_6122, 1'b0, 4'd3}, // R3
    '{PRV_S, 12'h300, OP_READ,  1'b0, 32'h0,        32'h0,        1'b1, 4'd2},  // R2
    '{PRV_M, 12'h300, OP_WRITE, 1'b0, 32'h0000_1000, 32'h807679AA, 1'b0, 4'd3}, // R3
    '{PRV_M, 12'h300, OP_READ,  1'b0, 32'h0,        32'h0000_1800, 1'b0, 4'd10}, // R10
    '{PRV_M, 12'h301, OP_WRITE, 1'b0, 32'h0,        32'h4014_1100, 1'b0, 4'd5},  // R5
    '{PRV_M, 12'h301, OP_READ,  1'b0, 32'h0,        32'h4014_1100, 1'b0, 4'd5},  // R5
    '{PRV_M, 12'h305, OP_WRITE, 1'b0, 32'h8000_0101, 32'h0,       1'b0, 4'd6},  // R6
    '{PRV_M, 12'h305, OP_READ,  1'b0, 32'h0,        32'h8000_0100, 1'b0, 4'd6},  // R6
    '{PRV_S, 12'h105, OP_WRITE, 1'b0, 32'h1234_5679, 32'h0,       1'b0, 4'd6},  // R6
    '{PRV_S, 12'h105, OP_READ,  1'b0, 32'h0,        32'h1234_5678, 1'b0, 4'd6},  // R6
    '{PRV_U, 12'h105, OP_READ,  1'b0, 32'h0,        32'h0,        1'b1, 4'd2},  // R2
    '{PRV_S, 12'h180, OP_WRITE, 1'b0, 32'hFFFF_FFFF, 32'h0,       1'b0, 4'd9},  // R9
    '{PRV_S, 12'h180, OP_READ,  1'b0, 32'h0,        32'h0,        1'b0, 4'd9},  // R9
    '{PRV_M, 12'h306, OP_WRITE, 1'b0, 32'hFFFF_FFFF, 32'h0,       1'b0, 4'd7},  // R7
    '{PRV_M, 12'h306, OP_READ,  1'b0, 32'h0,        32'h0000_0007, 1'b0, 4'd7}, // R7
    '{PRV_S, 12'h106, OP_WRITE, 1'b0, 32'h0000_0005, 32'h0,       1'b0, 4'd7},  // R7
    '{PRV_U, 12'h106, OP_WRITE, 1'b0, 32'h0,        32'h0,        1'b1, 4'd2},  // R2
    '{PRV_S, 12'h106, OP_READ,  1'b0, 32'h0,        32'h0000_0005, 1'b0, 4'd2}, // R2
    '{PRV_M, 12'h7C0, OP_READ,  1'b0, 32'h0,        32'h0,        1'b1, 4'd2},  // R2
    '{PRV_M, 12'hC00, OP_WRITE, 1'b0, 32'h0,        32'h0,        1'b1, 4'd3}   // R3
  };

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] pr, input logic [11:0] a,
                       input logic [1:0] op, input logic x0, input logic [31:0] wd,
                       input logic ret, input logic dwe, input logic [11:0] da,
                       input logic [31:0] dwd);
    @(negedge clk_i);
    req_valid_i = v; req_priv_i = pr; req_addr_i = a; req_op_i = op;
    req_src_x0_i = x0; req_wdata_i = wd; retire_i = ret;
    dbg_we_i = dwe; dbg_addr_i = da; dbg_wdata_i = dwd;
    #1;
  endtask

  task automatic rq(input logic [1:0] pr, input logic [11:0] a, input logic [1:0] op,
                    input logic x0, input logic [31:0] wd);
    drive(1'b1, pr, a, op, x0, wd, 1'b0, 1'b0, 12'h0, 32'h0);
  endtask

  task automatic expect_req(input string rq_tag, input logic [31:0] exp, input logic ill);
    check(req_illegal_o === ill, {rq_tag, " illegal"}, 32'(req_illegal_o), 32'(ill));
    check(req_rdata_o === exp, {rq_tag, " rdata"}, req_rdata_o, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] a0, a1;
    repeat (3) @(negedge clk_i);
    // reset state via debug port: R4
    dbg_addr_i = A_MTVEC; #1;
    check(dbg_rdata_o === 32'h0 && dbg_exists_o === 1'b1, "R4 reset mtvec", dbg_rdata_o, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      rq(VECS[i].priv, VECS[i].addr, VECS[i].op, VECS[i].x0, VECS[i].wd);
      expect_req($sformatf("R%0d row %0d", VECS[i].rq, i), VECS[i].exp_rd, VECS[i].exp_ill);
    end

    // R7 counter gating with mcounteren=7, scounteren=5
    rq(PRV_U, A_CYCLE, OP_READ, 1'b0, 0);
    check(req_illegal_o === 1'b0, "R7 U cycle allowed", 32'(req_illegal_o), 0);
    rq(PRV_U, A_TIME, OP_READ, 1'b0, 0);
    check(req_illegal_o === 1'b1, "R7 U time blocked", 32'(req_illegal_o), 1);
    rq(PRV_S, A_TIME, OP_READ, 1'b0, 0);
    check(req_illegal_o === 1'b0, "R7 S time allowed", 32'(req_illegal_o), 0);
    rq(PRV_M, A_MCOUNTEREN, OP_WRITE, 1'b0, 32'h6);
    rq(PRV_S, A_CYCLE, OP_READ, 1'b0, 0);
    check(req_illegal_o === 1'b1, "R7 S cycle blocked", 32'(req_illegal_o), 1);
    rq(PRV_U, A_INSTRET, OP_READ, 1'b0, 0);
    check(req_illegal_o === 1'b0, "R7 U instret allowed", 32'(req_illegal_o), 0);

    // R3 read-only with x0 operand
    rq(PRV_M, A_CYCLE, OP_SET, 1'b1, 32'hFFFF_FFFF);
    check(req_illegal_o === 1'b0, "R3 set x0 on ro", 32'(req_illegal_o), 0);
    rq(PRV_M, A_INSTRET, OP_CLEAR, 1'b0, 32'h1);
    check(req_illegal_o === 1'b1, "R3 clear on ro", 32'(req_illegal_o), 1);

    // R11 cycle counts every clock
    rq(PRV_M, A_MCYCLE, OP_READ, 1'b0, 0); a0 = req_rdata_o;
    rq(PRV_M, A_MCYCLE, OP_READ, 1'b0, 0);
    rq(PRV_M, A_MCYCLE, OP_READ, 1'b0, 0);
    rq(PRV_M, A_MCYCLE, OP_READ, 1'b0, 0);
    rq(PRV_M, A_MCYCLE, OP_READ, 1'b0, 0); a1 = req_rdata_o;
    check(a1 - a0 == 32'd4, "R11 cycle delta", a1 - a0, 32'd4);

    // R12 write beats increment
    rq(PRV_M, A_MCYCLE, OP_WRITE, 1'b0, 32'd100);
    rq(PRV_M, A_MCYCLE, OP_READ, 1'b0, 0);
    expect_req("R12 mcycle written", 32'd100, 1'b0);
    rq(PRV_M, A_CYCLE, OP_READ, 1'b0, 0);
    expect_req("R11 cycle alias", 32'd101, 1'b0);
    rq(PRV_M, A_MCYCLEH, OP_WRITE, 1'b0, 32'h5);
    rq(PRV_M, A_TIMEH, OP_READ, 1'b0, 0);
    expect_req("R11 timeh alias", 32'h5, 1'b0);

    // R12 instret write with retire in the same cycle, then R11 counting
    drive(1'b1, PRV_M, A_MINSTRET, OP_WRITE, 1'b0, 32'd0, 1'b1, 1'b0, 12'h0, 32'h0);
    drive(1'b1, PRV_M, A_MINSTRET, OP_READ, 1'b0, 32'd0, 1'b1, 1'b0, 12'h0, 32'h0);
    expect_req("R12 minstret written", 32'd0, 1'b0);
    drive(1'b1, PRV_M, A_MINSTRET, OP_READ, 1'b0, 32'd0, 1'b0, 1'b0, 12'h0, 32'h0);
    expect_req("R11 minstret retire", 32'd1, 1'b0);
    rq(PRV_M, A_MINSTRET, OP_READ, 1'b0, 0);
    expect_req("R11 minstret idle", 32'd1, 1'b0);

    // R4 debug port
    drive(1'b0, PRV_U, 12'h0, OP_READ, 1'b0, 0, 1'b0, 1'b0, A_MSTATUS, 0);
    check(dbg_rdata_o === 32'h0000_1800 && dbg_exists_o === 1'b1, "R4 dbg mstatus", dbg_rdata_o, 32'h0000_1800);
    drive(1'b0, PRV_U, 12'h0, OP_READ, 1'b0, 0, 1'b0, 1'b0, 12'h7C0, 0);
    check(dbg_exists_o === 1'b0, "R4 dbg absent", 32'(dbg_exists_o), 0);
    drive(1'b1, PRV_M, A_MISA, OP_READ, 1'b0, 0, 1'b0, 1'b1, A_MTVEC, 32'h400);
    rq(PRV_M, A_MTVEC, OP_READ, 1'b0, 0);
    expect_req("R4 dbg write yields", 32'h8000_0100, 1'b0);
    drive(1'b0, PRV_U, 12'h0, OP_READ, 1'b0, 0, 1'b0, 1'b1, A_MTVEC, 32'h203);
    rq(PRV_M, A_MTVEC, OP_READ, 1'b0, 0);
    expect_req("R4 dbg write mtvec", 32'h0000_0200, 1'b0);
    drive(1'b0, PRV_U, 12'h0, OP_READ, 1'b0, 0, 1'b0, 1'b1, A_SATP, 32'hFFFF_FFFF);
    rq(PRV_S, A_SATP, OP_READ, 1'b0, 0);
    expect_req("R9 dbg satp", 32'h0, 1'b0);

    drive(1'b0, PRV_M, 12'h0, OP_READ, 1'b0, 0, 1'b0, 1'b0, 12'h0, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule